// File: doc/BRIEF.md
# Triplicated State Machine with Voted Realignment

This block holds three copies of one small state machine, a modulo counter that steps up or down on an event input. Each clock a bitwise majority of the three state registers gives the healthy present state. That state drives the block's outputs, and it is also fed back into every copy's next-state logic as an extra input. When a copy has just been repaired and holds stale contents, the system raises that copy's realignment request. On the request's rising edge, the copy computes its next state from the healthy state instead of from its own register. It rejoins the other two within one clock, and the two sound copies never pause. No snapshot of state is stored anywhere.

Each copy can be loaded with an arbitrary value through a per-copy load port. This port models the unknown contents a copy holds after it has been rebuilt. A per-copy disagreement flag shows which registers differ from the healthy state, so the surrounding system can see which copy needs attention and confirm that realignment worked.

Top module: `tmr_fsm_resync`

## Requirements
- R1: While rst_n is low, every copy is cleared to 0. After reset, state_o is 0, mismatch_o is 3'b000 and sync_done_o is 0.
- R2: With step_i high, a copy's next state is (s+1) mod MOD when down_i is 0, and (s-1) mod MOD when down_i is 1. Any register value of MOD or above goes to 0 when counting up and to MOD-1 when counting down. With step_i low, the state holds.
- R3: wrap_o is 1 exactly when state_o equals MOD-1.
- R4: state_o is the bitwise majority of the three state registers. A single corrupted copy therefore leaves state_o on the value of the other two.
- R5: mismatch_o[i] is 1 exactly when copy i's register differs from state_o. Bit 0 is copy 0, bit 1 is copy 1 and bit 2 is copy 2.
- R6: When load_we_i[i] is high at a clock edge, copy i takes load_val_i. This takes priority over stepping and over realignment.
- R7: A request is accepted on a clock edge where sync_req_i is one-hot and its set bit was 0 at the previous edge. The selected copy then takes the next state computed from state_o, so its mismatch bit clears after that edge.
- R8: sync_done_o is 1 for the single cycle that follows each accepted request.
- R9: A request held high is not accepted again. While sync_req_i stays unchanged, sync_done_o remains 0 from the next cycle on.
- R10: When two or more bits of sync_req_i are high, no copy is realigned and sync_done_o stays 0.
- R11: Realignment does not stall the sound copies. With at most one copy in disagreement, state_o keeps following the step rule of R2 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance the state machine this cycle |
| down_i | input | 1 | Step direction: 0 up, 1 down |
| load_we_i | input | 3 | Per-copy load strobe (models rebuilt contents) |
| load_val_i | input | SW | Value written by load_we_i |
| sync_req_i | input | 3 | Per-copy realignment request |
| state_o | output | SW | Voted healthy state |
| wrap_o | output | 1 | Voted state is at MOD-1 |
| mismatch_o | output | 3 | Copy register differs from voted state |
| sync_done_o | output | 1 | One-cycle pulse after an accepted request |

## Verification
The assertions check the following on every clock:
- The state holds when no step occurs and all copies agree.
- state_o follows the step rule while at most one copy disagrees, even in cycles when a copy is being realigned.
- An accepted request that is not overridden by a load clears all disagreement.
- A completion pulse follows each accepted request.
- Requests that are held or multi-hot produce no pulse.

Other properties depend on data values rather than on control timing, and only the bench's scenarios can show them. These are the bitwise majority over arbitrary corrupted values, including values outside the counter range. They also include the priority of a load over a realignment in the same cycle, and the modulo wrap in both directions.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Bitwise two-of-three majority on a 32-bit carrier; callers truncate.
  function automatic logic [31:0] maj3(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input logic [31:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Modulo up/down step; out-of-range values fold to the wrap target.
  function automatic int unsigned step_st(input int unsigned s,
                                          input logic        step,
                                          input logic        down,
                                          input int unsigned modulus);
    if (!step) return s;
    if (!down) return (s >= modulus - 1) ? 0 : s + 1;
    return (s == 0 || s >= modulus) ? modulus - 1 : s - 1;
  endfunction

  // True when exactly one bit of a 3-bit vector is set.
  function automatic logic one_hot3(input logic [2:0] v);
    return (v == 3'b001) || (v == 3'b010) || (v == 3'b100);
  endfunction

endpackage

// File: rtl/rs_replica.sv
module rs_replica #(
  parameter int MOD = 10,
  parameter int SW  = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          down_i,
  input  logic [SW-1:0] healthy_i,
  input  logic          realign_i,
  input  logic          load_we_i,
  input  logic [SW-1:0] load_val_i,
  output logic [SW-1:0] q_o
);
  import rs_pkg::*;

  logic [SW-1:0] present_st;
  logic [SW-1:0] next_st;

  // The present state seen by the next-state logic is either the copy's
  // own register or the voted healthy state.
  assign present_st = realign_i ? healthy_i : q_o;
  assign next_st    = SW'(step_st(32'(present_st), step_i, down_i, MOD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q_o <= '0;
    else if (load_we_i) q_o <= load_val_i;
    else                q_o <= next_st;
  end

endmodule

// File: rtl/rs_voter.sv
module rs_voter #(
  parameter int SW = 4
) (
  input  logic [2:0][SW-1:0] rep_q_i,
  output logic [SW-1:0]      voted_o,
  output logic [2:0]         differ_o
);
  import rs_pkg::*;

  assign voted_o = SW'(maj3(32'(rep_q_i[0]), 32'(rep_q_i[1]), 32'(rep_q_i[2])));

  for (genvar g = 0; g < 3; g++) begin : g_cmp
    assign differ_o[g] = (rep_q_i[g] != voted_o);
  end

endmodule

// File: rtl/rs_sync_ctl.sv
module rs_sync_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req_i,
  output logic [2:0] go_o,
  output logic       done_o
);
  import rs_pkg::*;

  logic [2:0] req_q;
  logic [2:0] req_rise;

  // Previous request level, captured on every edge including reset, so a
  // request held across reset is not taken as new.
  always_ff @(posedge clk) req_q <= req_i;

  assign req_rise = req_i & ~req_q;
  assign go_o     = one_hot3(req_i) ? req_rise : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= |go_o;
  end

endmodule

// File: rtl/tmr_fsm_resync.sv
module tmr_fsm_resync #(
  parameter int MOD = 10,
  localparam int SW = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          down_i,
  input  logic [2:0]    load_we_i,
  input  logic [SW-1:0] load_val_i,
  input  logic [2:0]    sync_req_i,
  output logic [SW-1:0] state_o,
  output logic          wrap_o,
  output logic [2:0]    mismatch_o,
  output logic          sync_done_o
);

  logic [2:0][SW-1:0] rep_q;
  logic [SW-1:0]      healthy;
  logic [2:0]         sync_go;

  rs_sync_ctl u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (sync_req_i),
    .go_o   (sync_go),
    .done_o (sync_done_o)
  );

  for (genvar g = 0; g < 3; g++) begin : g_rep
    rs_replica #(.MOD(MOD), .SW(SW)) u_rep (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step_i),
      .down_i     (down_i),
      .healthy_i  (healthy),
      .realign_i  (sync_go[g]),
      .load_we_i  (load_we_i[g]),
      .load_val_i (load_val_i),
      .q_o        (rep_q[g])
    );
  end

  rs_voter #(.SW(SW)) u_vote (
    .rep_q_i  (rep_q),
    .voted_o  (healthy),
    .differ_o (mismatch_o)
  );

  assign state_o = healthy;
  assign wrap_o  = (healthy == SW'(MOD - 1));

endmodule

// File: rtl/tmr_fsm_resync_chk.sv
module tmr_fsm_resync_chk #(
  parameter int MOD = 10,
  localparam int SW = (MOD > 1) ? $clog2(MOD) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_i,
  input logic          down_i,
  input logic [2:0]    load_we_i,
  input logic [2:0]    sync_req_i,
  input logic [SW-1:0] state_o,
  input logic [2:0]    mismatch_o,
  input logic          sync_done_o,
  input logic [2:0]    sync_go
);
  import rs_pkg::*;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && load_we_i == 3'b000 && mismatch_o == 3'b000) |=> $stable(state_o));

  // R11
  no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_we_i == 3'b000 && $countones(mismatch_o) <= 1) |=>
      (state_o == SW'(step_st(32'($past(state_o)), $past(step_i), $past(down_i), MOD))));

  // R7
  realign_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_go != 3'b000 && load_we_i == 3'b000 && (mismatch_o & ~sync_go) == 3'b000)
      |=> (mismatch_o == 3'b000));

  // R8
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_go != 3'b000) |=> sync_done_o);

  // R9
  held_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sync_req_i) |=> !sync_done_o);

  // R10
  multi_req_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sync_req_i) > 1) |=> !sync_done_o);

endmodule

bind tmr_fsm_resync tmr_fsm_resync_chk #(.MOD(MOD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_i      (step_i),
  .down_i      (down_i),
  .load_we_i   (load_we_i),
  .sync_req_i  (sync_req_i),
  .state_o     (state_o),
  .mismatch_o  (mismatch_o),
  .sync_done_o (sync_done_o),
  .sync_go     (sync_go)
);

// File: tb/tmr_fsm_resync_bench.sv
module tmr_fsm_resync_bench;
  localparam int MOD = 10;
  localparam int SW  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step_i, down_i;
  logic [2:0]    load_we_i, sync_req_i;
  logic [SW-1:0] load_val_i;
  logic [SW-1:0] state_o;
  logic          wrap_o, sync_done_o;
  logic [2:0]    mismatch_o;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model state
  int m[3];
  bit pr[3];
  bit mdone;

  always #10 clk = ~clk;

  tmr_fsm_resync #(.MOD(MOD)) u_tmr_fsm_resync (
    .clk, .rst_n, .step_i, .down_i, .load_we_i, .load_val_i,
    .sync_req_i, .state_o, .wrap_o, .mismatch_o, .sync_done_o
  );

  function automatic int nx(int s, bit e, bit d);
    if (!e) return s;
    if (!d) begin
      if (s + 1 >= MOD) return 0;
      return s + 1;
    end
    if (s == 0 || s >= MOD) return MOD - 1;
    return s - 1;
  endfunction

  function automatic int vote();
    int r = 0;
    for (int b = 0; b < SW; b++) begin
      int cnt = ((m[0] >> b) & 1) + ((m[1] >> b) & 1) + ((m[2] >> b) & 1);
      if (cnt >= 2) r += (1 << b);
    end
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit e, bit d, bit [2:0] fw, int fv, bit [2:0] rq);
    int v;
    int nm[3];
    int ones;
    step_i = e; down_i = d; load_we_i = fw; load_val_i = SW'(fv); sync_req_i = rq;
    @(posedge clk);
    ones = rq[0] + rq[1] + rq[2];
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m[i] = 0;
      mdone = 0;
    end else begin
      v = vote();
      mdone = 0;
      for (int i = 0; i < 3; i++) begin
        bit g = (ones == 1) && rq[i] && !pr[i];
        if (g) mdone = 1;
        if (fw[i])  nm[i] = fv % (1 << SW);
        else if (g) nm[i] = nx(v, e, d);
        else        nm[i] = nx(m[i], e, d);
      end
      for (int i = 0; i < 3; i++) m[i] = nm[i];
    end
    for (int i = 0; i < 3; i++) pr[i] = rq[i];
    @(negedge clk);
    v = vote();
    chk("R2/R4 state", int'(state_o), v);
    chk("R3 wrap", int'(wrap_o), (v == MOD - 1) ? 1 : 0);
    for (int i = 0; i < 3; i++)
      chk("R5 mismatch", int'(mismatch_o[i]), (m[i] != v) ? 1 : 0);
    chk("R8 done", int'(sync_done_o), int'(mdone));
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    cyc(0, 0, 3'b000, 0, 3'b000);
    cyc(0, 0, 3'b000, 0, 3'b000);
    // R1 reset state
    chk("R1 state", int'(state_o), 0);
    chk("R1 mismatch", int'(mismatch_o), 0);
    chk("R1 done", int'(sync_done_o), 0);
    rst_n = 1'b1;

    // R2 up across the wrap, then down across zero
    for (int k = 0; k < 12; k++) cyc(1, 0, 3'b000, 0, 3'b000);
    chk("R2 up wrap", int'(state_o), 2);
    for (int k = 0; k < 3; k++) cyc(1, 1, 3'b000, 0, 3'b000);
    chk("R2 down wrap", int'(state_o), 9);
    chk("R3 wrap at 9", int'(wrap_o), 1);
    cyc(0, 0, 3'b000, 0, 3'b000);
    chk("R2 hold", int'(state_o), 9);

    // R6/R4 corrupt copy 1
    cyc(0, 0, 3'b010, 5, 3'b000);
    chk("R6 load", int'(mismatch_o), 3'b010);
    chk("R4 masked", int'(state_o), 9);
    cyc(1, 0, 3'b000, 0, 3'b000);
    chk("R4 still voted", int'(state_o), 0);

    // R7/R8/R11 realign copy 1 while stepping
    cyc(1, 0, 3'b000, 0, 3'b010);
    chk("R7 realigned", int'(mismatch_o), 0);
    chk("R8 pulse", int'(sync_done_o), 1);
    chk("R11 no stall", int'(state_o), 1);
    cyc(0, 0, 3'b000, 0, 3'b010);
    cyc(0, 0, 3'b000, 0, 3'b010);
    chk("R9 held quiet", int'(sync_done_o), 0);
    cyc(0, 0, 3'b000, 0, 3'b000);

    // R10 two requests at once
    cyc(0, 0, 3'b100, 14, 3'b000);
    chk("R6 out of range", int'(mismatch_o), 3'b100);
    cyc(0, 0, 3'b000, 0, 3'b101);
    chk("R10 not realigned", int'(mismatch_o), 3'b100);
    chk("R10 no done", int'(sync_done_o), 0);
    cyc(0, 0, 3'b000, 0, 3'b000);
    cyc(1, 1, 3'b000, 0, 3'b100);
    chk("R7 copy 2", int'(mismatch_o), 0);
    chk("R11 down", int'(state_o), 0);
    cyc(0, 0, 3'b000, 0, 3'b000);

    // R6 load beats realign in the same cycle
    cyc(0, 0, 3'b001, 3, 3'b001);
    chk("R6 priority", int'(mismatch_o), 3'b001);
    cyc(0, 0, 3'b000, 0, 3'b000);
    cyc(1, 0, 3'b000, 0, 3'b001);
    chk("R7 copy 0", int'(mismatch_o), 0);

    // Random traffic against the model
    for (int k = 0; k < 600; k++) begin
      bit [2:0] fw = 3'b000;
      bit [2:0] rq = 3'b000;
      if ($urandom % 16 == 0) fw = 3'(1 << ($urandom % 3));
      if ($urandom % 4 == 0)  rq = 3'($urandom % 8);
      cyc(1'($urandom % 2), 1'($urandom % 2), fw, int'($urandom % 16), rq);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule